// File: doc/BRIEF.md
# Stability-Checked Multi-Bit Bus Synchronizer

This block carries a wide status or result bus from a source clock domain into a destination domain without a FIFO. Every bit of the incoming bus passes through its own chain of flip-flops clocked by the destination clock. Bits of one bus can reach the destination with different routing delays. A source update can therefore land in the chain over two consecutive destination edges, with some bits one cycle late.

To keep such a torn word from reaching downstream logic, the block compares the last two stages of the chain on every destination cycle. Only when the two agree does it load the output register and raise the valid flag. When the stages differ, the output keeps its last value and valid drops. Downstream logic reads the bus only while valid is high.

The source must hold each value steady for at least three destination clock periods between changes. The bus width and the chain depth are parameters. The defaults are 128 bits and two stages.

Top module: `bus_stable_sync`

## Requirements
- R1: While `rst_dst_n` is low, `bus_o` is all zeros and `valid_o` is 0, whatever `bus_i` carries.
- R2: Number the destination rising edges after reset release 1, 2, 3 and so on. After edges 1 and 2, `valid_o` is 0 and `bus_o` stays zero, because the chain is still filling.
- R3: From edge 3 on, `valid_o` after edge n is 1 exactly when the value of `bus_i` sampled at edge n-1 equals the value sampled at edge n-2.
- R4: Whenever `valid_o` is 1 after edge n, `bus_o` equals the value of `bus_i` sampled at edge n-2.
- R5: After any edge at which `valid_o` ends up 0, `bus_o` keeps the value it had before that edge.
- R6: When a new value is first sampled at edge m and then held, `valid_o` is 1 and `bus_o` carries that value after edge m+2.
- R7: Suppose an update reaches the destination torn, with part of the bits one edge later than the rest. Then `valid_o` goes low for at least one cycle, and the partial mix is never presented on `bus_o` while `valid_o` is 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_dst | input | 1 | Destination domain clock |
| rst_dst_n | input | 1 | Asynchronous active-low reset, destination domain |
| bus_i | input | WIDTH | Source bus, asynchronous to clk_dst |
| bus_o | output | WIDTH | Last bus value that passed the stability compare |
| valid_o | output | 1 | High while bus_o holds a value that passed the compare on the latest edge |

## Verification
A new source value is first captured at one edge. The compare sees it in both tail stages one edge later, and it appears on `bus_o` with `valid_o` high one edge after that. The whole path is three edges from the first capture. The bench keeps a short history of the source value it presented at each destination edge. From that history it predicts valid and data for edge n from the samples at n-1 and n-2. It compares these predictions with the outputs 1 ns after every rising edge, once the registers have settled. The directed torn-update and hold scenarios check their results on the edges this counting gives: the third sampling edge for a held value, and the following five edges for a torn one.

// File: rtl/bsync_pkg.sv
package bsync_pkg;
   // width of a saturating counter that must reach the value n
   function automatic int sat_cnt_bits(input int n);
      return (n < 1) ? 1 : $clog2(n + 1);
   endfunction
endpackage

// File: rtl/bsync_bit_chain.sv
module bsync_bit_chain #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic d,
   output logic tap_last,
   output logic tap_prev
);
   logic [STAGES-1:0] sr;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) sr <= '0;
      else        sr <= {sr[STAGES-2:0], d};
   end

   assign tap_last = sr[STAGES-1];
   assign tap_prev = sr[STAGES-2];
endmodule

// File: rtl/bsync_stage_chain.sv
module bsync_stage_chain #(
   parameter int WIDTH  = 128,
   parameter int STAGES = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] d,
   output logic [WIDTH-1:0] last_q,
   output logic [WIDTH-1:0] prev_q
);
   for (genvar b = 0; b < WIDTH; b++) begin : g_bit
      bsync_bit_chain #(.STAGES(STAGES)) u_chain (
         .clk      (clk),
         .rst_n    (rst_n),
         .d        (d[b]),
         .tap_last (last_q[b]),
         .tap_prev (prev_q[b])
      );
   end
endmodule

// File: rtl/bsync_eq_gate.sv
module bsync_eq_gate
   import bsync_pkg::*;
#(
   parameter int WIDTH  = 128,
   parameter int STAGES = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] last_q,
   input  logic [WIDTH-1:0] prev_q,
   output logic             agree,
   output logic             ready
);
   localparam int CW = sat_cnt_bits(STAGES);
   localparam logic [CW-1:0] FILL = CW'(STAGES);

   logic [CW-1:0] fill_cnt;

   // chain is only meaningful once every stage has seen a real sample
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                fill_cnt <= '0;
      else if (fill_cnt != FILL) fill_cnt <= fill_cnt + 1'b1;
   end

   assign ready = (fill_cnt == FILL);
   assign agree = (last_q == prev_q);
endmodule

// File: rtl/bsync_hold_reg.sv
module bsync_hold_reg #(
   parameter int WIDTH = 128
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load,
   input  logic [WIDTH-1:0] d,
   output logic [WIDTH-1:0] q,
   output logic             vld
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         q   <= '0;
         vld <= 1'b0;
      end else begin
         vld <= load;
         if (load) q <= d;
      end
   end
endmodule

// File: rtl/bus_stable_sync.sv
module bus_stable_sync #(
   parameter int WIDTH  = 128,
   parameter int STAGES = 2
) (
   input  logic             clk_dst,
   input  logic             rst_dst_n,
   input  logic [WIDTH-1:0] bus_i,
   output logic [WIDTH-1:0] bus_o,
   output logic             valid_o
);
   if (WIDTH < 1) begin : g_bad_width
      $error("bus_stable_sync: WIDTH must be at least 1");
   end
   if (STAGES < 2 || STAGES > 200) begin : g_bad_stages
      $error("bus_stable_sync: STAGES must lie in 2..200");
   end

   logic [WIDTH-1:0] sync_last;
   logic [WIDTH-1:0] sync_prev;
   logic             agree;
   logic             ready;

   bsync_stage_chain #(.WIDTH(WIDTH), .STAGES(STAGES)) u_chain (
      .clk    (clk_dst),
      .rst_n  (rst_dst_n),
      .d      (bus_i),
      .last_q (sync_last),
      .prev_q (sync_prev)
   );

   bsync_eq_gate #(.WIDTH(WIDTH), .STAGES(STAGES)) u_gate (
      .clk    (clk_dst),
      .rst_n  (rst_dst_n),
      .last_q (sync_last),
      .prev_q (sync_prev),
      .agree  (agree),
      .ready  (ready)
   );

   bsync_hold_reg #(.WIDTH(WIDTH)) u_out (
      .clk   (clk_dst),
      .rst_n (rst_dst_n),
      .load  (agree && ready),
      .d     (sync_last),
      .q     (bus_o),
      .vld   (valid_o)
   );
endmodule

// File: rtl/bsync_chk.sv
module bsync_chk #(
   parameter int WIDTH  = 128,
   parameter int STAGES = 2
) (
   input logic             clk,
   input logic             rst_n,
   input logic             agree,
   input logic [WIDTH-1:0] sync_last,
   input logic [WIDTH-1:0] bus_o,
   input logic             valid_o
);
   logic [7:0] cyc;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)            cyc <= '0;
      else if (cyc != 8'hFF) cyc <= cyc + 8'd1;
   end

   // R2
   warmup_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (cyc <= 8'(STAGES)) |-> !valid_o);

   // R3
   valid_needs_agree_chk: assert property (@(posedge clk) disable iff (!rst_n)
      valid_o |-> $past(agree));

   // R4
   data_from_tail_chk: assert property (@(posedge clk) disable iff (!rst_n)
      valid_o |-> (bus_o == $past(sync_last)));

   // R5
   hold_when_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !valid_o |-> $stable(bus_o));

   // R7
   mismatch_drops_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !agree |=> !valid_o);
endmodule

bind bus_stable_sync bsync_chk #(.WIDTH(WIDTH), .STAGES(STAGES)) u_bsync_chk (
   .clk       (clk_dst),
   .rst_n     (rst_dst_n),
   .agree     (agree),
   .sync_last (sync_last),
   .bus_o     (bus_o),
   .valid_o   (valid_o)
);

// File: tb/tb_bus_stable_sync.sv
module tb_bus_stable_sync;
   localparam int W   = 128;
   localparam int PER = 8;

   logic         clk   = 1'b0;
   logic         rst_n = 1'b0;
   logic [W-1:0] src   = '0;
   logic [W-1:0] bus_o;
   logic         valid_o;

   int checks = 0;
   int errors = 0;
   bit done   = 1'b0;

   always #(PER/2) clk = ~clk;

   bus_stable_sync #(.WIDTH(W), .STAGES(2)) dut (
      .clk_dst   (clk),
      .rst_dst_n (rst_n),
      .bus_i     (src),
      .bus_o     (bus_o),
      .valid_o   (valid_o)
   );

   task automatic chk(input string tag, input logic [W-1:0] act, input logic [W-1:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   // behavioural reference: history of values presented at each edge
   logic [W-1:0] hist[$];
   int           n_edge = 0;
   logic         exp_v  = 1'b0;
   logic [W-1:0] exp_d  = '0;

   always @(posedge clk) begin
      if (!rst_n) begin
         n_edge = 0;
         hist.delete();
         exp_v = 1'b0;
         exp_d = '0;
      end else begin
         n_edge++;
         hist.push_back(src);
         if (hist.size() > 3) void'(hist.pop_front());
         exp_v = (n_edge >= 3) && (hist[hist.size()-2] == hist[hist.size()-3]);
         if (exp_v) exp_d = hist[hist.size()-3];
      end
      #1;
      if (!done) begin
         if (!rst_n) begin
            chk("R1 valid in reset", W'(valid_o), W'(1'b0));
            chk("R1 bus in reset", bus_o, '0);
         end else if (n_edge < 3) begin
            chk("R2 valid during fill", W'(valid_o), W'(1'b0));
            chk("R2 bus during fill", bus_o, '0);
         end else begin
            chk("R3 valid", W'(valid_o), W'(exp_v));
            chk(exp_v ? "R4 bus" : "R5 bus hold", bus_o, exp_d);
         end
      end
   end

   task automatic hold_new(input logic [W-1:0] v, input int extra);
      @(negedge clk) src = v;
      repeat (3) @(posedge clk);
      #2;
      chk("R6 valid after third edge", W'(valid_o), W'(1'b1));
      chk("R6 bus after third edge", bus_o, v);
      repeat (extra) @(negedge clk);
   endtask

   task automatic torn_update(input logic [W-1:0] nv, input logic [W-1:0] mask);
      logic [W-1:0] mix;
      bit           saw_low;
      mix     = (src & mask) | (nv & ~mask);
      saw_low = 1'b0;
      @(negedge clk) src = mix;
      @(negedge clk) src = nv;
      for (int i = 0; i < 5; i++) begin
         @(posedge clk);
         #2;
         if (!valid_o) saw_low = 1'b1;
         chk("R7 torn word never valid", W'(valid_o && (bus_o == mix)), W'(1'b0));
      end
      chk("R7 valid dropped", W'(saw_low), W'(1'b1));
      repeat (2) @(negedge clk);
   endtask

   initial begin
      src = {4{32'hDEAD_BEEF}};
      repeat (3) @(negedge clk);
      @(negedge clk) begin
         rst_n = 1'b1;
         src   = '0;
      end
      repeat (4) @(negedge clk);

      hold_new({4{32'h1234_5678}}, 1);
      hold_new({W{1'b1}}, 2);
      for (int k = 0; k < 8; k++) hold_new(W'(1) << (k * 17), 0);
      hold_new({64'h0, 64'hFFFF_0000_FFFF_0000}, 3);

      // fast toggling violates the hold rule: valid must stay low, output held
      for (int k = 0; k < 6; k++) @(negedge clk) src = ~src;
      repeat (4) @(negedge clk);

      torn_update({4{32'hA5A5_5A5A}}, {32'h0, {64{1'b1}}, 32'h0});
      torn_update({4{32'h0F0F_F0F0}}, {{64{1'b1}}, 64'h0});
      hold_new({4{32'hCAFE_0001}}, 4);

      // reset mid-run clears everything
      @(negedge clk) rst_n = 1'b0;
      repeat (2) @(negedge clk);
      rst_n = 1'b1;
      repeat (5) @(negedge clk);

      done = 1'b1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      #(PER * 200000);
      if (!done) begin
         done = 1'b1;
         checks++;
         errors++;
         $display("FAIL watchdog actual=hung expected=finished");
         $display("  CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end
endmodule